// File: doc/BRIEF.md
# Masked Address Cycle Trap Decoder

This block sits beside a simple host bus and watches for cycles that fall inside a small number of user-defined device windows (three by default). Each window has a 16-bit base register and an 8-bit control byte. The control byte chooses whether the window decodes I/O or memory cycles. It also carries an ignore mask whose meaning depends on that choice. In I/O mode it separately enables trapping of reads and of writes. A trapped cycle sets a sticky per-window flag and raises a system-management interrupt request for one clock. A software trigger register raises the same request when it is written.

Bus inputs are looked at only in cycles where the valid strobe is high. Configuration goes through a small indexed register port. The base registers sit at indices 0..2, the control bytes at 4..6, the status flags at 8 and the software trigger at 9. A write lands on the clock edge and is used by the decoder from the following cycle. Reads are combinational. The request output comes from a two-state machine. SMI_IDLE moves to SMI_FIRE when any trap or software trigger occurs. SMI_FIRE stays in SMI_FIRE if another event arrives and otherwise returns to SMI_IDLE. The request is high exactly while the machine is in SMI_FIRE.

Top module: `trap_decoder`

## Requirements
- R1: After reset, all base registers read 0000h, all control bytes read 00h, every status flag is 0 and `smi_req` is low.
- R2: With control bit 7 = 0 (I/O), a window hits only on an I/O cycle (`bus_mem` = 0). Address bits 15..5 must equal the base. For bits 4..0, control bits [4:0] act as a mask: a 1 excludes the matching address bit from the compare.
- R3: In I/O mode, control bit 6 = 1 lets write cycles (`bus_wr` = 1) hit, and bit 6 = 0 blocks them.
- R4: In I/O mode, control bit 5 = 1 lets read cycles (`bus_wr` = 0) hit, and bit 5 = 0 blocks them.
- R5: With control bit 7 = 1 (memory), a window hits on a memory cycle (`bus_mem` = 1) of either direction. Control bits [6:0] mask address bits 15..9 (1 = ignored). Address bits 8..0 are never compared. I/O cycles never hit a memory window.
- R6: A hit sets status bit i of window i (status index 8), and the bit stays set until 1 is written to it there. A hit in the same cycle as its clear leaves the bit set.
- R7: `smi_req` is high in the clock after a hit and otherwise low. Hits on several windows in one cycle give a single one-clock pulse.
- R8: Any write to index 9 gives a one-clock `smi_req` pulse whatever the data. Index 9 reads as 0.
- R9: Bus inputs are ignored in cycles where `bus_vld` is low.
- R10: A bus cycle presented in the same clock as a configuration write is decoded with the settings from before that write.
- R11: Base registers read back in full at indices 0..2, control bytes read back zero-extended at 4..6, and status reads back at 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_vld | input | 1 | Single-cycle bus strobe |
| bus_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 4 | Register index |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_sel` |
| dev_hit | output | 3 | Sticky per-window trap flags |
| smi_req | output | 1 | Interrupt request pulse |

## Verification
The assertions assume the bus strobe and the configuration port are both quiet while reset is held. They also assume a status clear is only a write to index 8. The bench drives every input at the falling edge and holds each bus strobe for exactly one clock. It keeps the port idle through reset and reaches the clear only through the normal register write. Same-cycle collisions are made on purpose: a hit together with its clear, and a bus cycle together with a control write. Both stay inside these assumptions.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int CTL_W       = 8;
    localparam int CTL_MODE    = 7;
    localparam int CTL_TRK_WR  = 6;
    localparam int CTL_TRK_RD  = 5;
    localparam int IO_MASK_W   = 5;
    localparam int MEM_MASK_W  = 7;
    localparam int MEM_LSB     = 9;

    localparam int IDX_BASE0   = 0;
    localparam int IDX_CTL0    = 4;
    localparam int IDX_STAT    = 8;
    localparam int IDX_SWSMI   = 9;

    typedef enum logic {
        SMI_IDLE = 1'b0,
        SMI_FIRE = 1'b1
    } smi_state_e;
endpackage

// File: rtl/trap_window.sv
module trap_window
    import trap_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              bus_vld,
    input  logic              bus_mem,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [CTL_W-1:0]  ctl,
    output logic              hit
);
    logic [ADDR_W-1:0] io_care;
    logic [ADDR_W-1:0] mem_care;
    logic [ADDR_W-1:0] care;
    logic [ADDR_W-1:0] diff;
    logic              dir_ok;

    for (genvar b = 0; b < ADDR_W; b++) begin : g_care
        if (b < IO_MASK_W) begin : g_io_m
            assign io_care[b] = ~ctl[b];
        end else begin : g_io_f
            assign io_care[b] = 1'b1;
        end
        if (b < MEM_LSB) begin : g_mem_lo
            assign mem_care[b] = 1'b0;
        end else if (b < MEM_LSB + MEM_MASK_W) begin : g_mem_m
            assign mem_care[b] = ~ctl[b-MEM_LSB];
        end else begin : g_mem_hi
            assign mem_care[b] = 1'b1;
        end
    end

    always_comb begin
        diff   = bus_addr ^ base;
        care   = ctl[CTL_MODE] ? mem_care : io_care;
        dir_ok = ctl[CTL_MODE] ? bus_mem
                               : (!bus_mem && (bus_wr ? ctl[CTL_TRK_WR] : ctl[CTL_TRK_RD]));
        hit    = bus_vld && dir_ok && ((diff & care) == '0);
    end
endmodule

// File: rtl/trap_regs.sv
module trap_regs
    import trap_pkg::*;
#(
    parameter int NUM_DEV = 3,
    parameter int ADDR_W  = 16,
    parameter int SEL_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [SEL_W-1:0]           cfg_sel,
    input  logic [ADDR_W-1:0]          cfg_wdata,
    input  logic [NUM_DEV-1:0]         hit_vec,
    output logic [NUM_DEV*ADDR_W-1:0]  base_flat,
    output logic [NUM_DEV*CTL_W-1:0]   ctl_flat,
    output logic [NUM_DEV-1:0]         status,
    output logic                       sw_fire,
    output logic [ADDR_W-1:0]          cfg_rdata
);
    logic [ADDR_W-1:0]  base_q [NUM_DEV];
    logic [CTL_W-1:0]   ctl_q  [NUM_DEV];
    logic [NUM_DEV-1:0] stat_q;
    logic [NUM_DEV-1:0] clr_vec;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                ctl_q[g]  <= '0;
            end else if (cfg_we) begin
                if (cfg_sel == SEL_W'(IDX_BASE0 + g)) base_q[g] <= cfg_wdata;
                if (cfg_sel == SEL_W'(IDX_CTL0 + g))  ctl_q[g]  <= cfg_wdata[CTL_W-1:0];
            end
        end
        assign base_flat[g*ADDR_W +: ADDR_W] = base_q[g];
        assign ctl_flat[g*CTL_W +: CTL_W]    = ctl_q[g];
    end

    always_comb begin
        clr_vec = (cfg_we && cfg_sel == SEL_W'(IDX_STAT)) ? cfg_wdata[NUM_DEV-1:0] : '0;
        sw_fire = cfg_we && (cfg_sel == SEL_W'(IDX_SWSMI));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= hit_vec | (stat_q & ~clr_vec);
    end
    assign status = stat_q;

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (cfg_sel == SEL_W'(IDX_BASE0 + i)) cfg_rdata = base_q[i];
            if (cfg_sel == SEL_W'(IDX_CTL0 + i))  cfg_rdata = ADDR_W'(ctl_q[i]);
        end
        if (cfg_sel == SEL_W'(IDX_STAT)) cfg_rdata = ADDR_W'(stat_q);
    end
endmodule

// File: rtl/trap_smi_fsm.sv
module trap_smi_fsm
    import trap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trap_any,
    input  logic sw_fire,
    output logic smi_o
);
    smi_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMI_IDLE: if (trap_any || sw_fire) state_d = SMI_FIRE;
            SMI_FIRE: state_d = (trap_any || sw_fire) ? SMI_FIRE : SMI_IDLE;
            default:  state_d = SMI_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SMI_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        smi_o = (state_q == SMI_FIRE);
    end
endmodule

// File: rtl/trap_decoder.sv
module trap_decoder
    import trap_pkg::*;
#(
    parameter int NUM_DEV = 3,
    parameter int ADDR_W  = 16,
    parameter int SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_vld,
    input  logic               bus_mem,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    output logic [ADDR_W-1:0]  cfg_rdata,
    output logic [NUM_DEV-1:0] dev_hit,
    output logic               smi_req
);
    logic [NUM_DEV*ADDR_W-1:0] base_flat;
    logic [NUM_DEV*CTL_W-1:0]  ctl_flat;
    logic [NUM_DEV-1:0]        hit_vec;
    logic                      sw_fire;

    trap_regs #(.NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .hit_vec(hit_vec), .base_flat(base_flat),
        .ctl_flat(ctl_flat), .status(dev_hit), .sw_fire(sw_fire),
        .cfg_rdata(cfg_rdata)
    );

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_win
        trap_window #(.ADDR_W(ADDR_W)) u_win (
            .bus_vld(bus_vld), .bus_mem(bus_mem), .bus_wr(bus_wr),
            .bus_addr(bus_addr), .base(base_flat[g*ADDR_W +: ADDR_W]),
            .ctl(ctl_flat[g*CTL_W +: CTL_W]), .hit(hit_vec[g])
        );
    end

    trap_smi_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .trap_any(|hit_vec),
        .sw_fire(sw_fire), .smi_o(smi_req)
    );
endmodule

// File: rtl/trap_decoder_chk.sv
module trap_decoder_chk
    import trap_pkg::*;
#(
    parameter int NUM_DEV = 3,
    parameter int ADDR_W  = 16,
    parameter int SEL_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_vld,
    input logic               cfg_we,
    input logic [SEL_W-1:0]   cfg_sel,
    input logic [ADDR_W-1:0]  cfg_wdata,
    input logic [NUM_DEV-1:0] dev_hit,
    input logic               smi_req
);
    logic [NUM_DEV-1:0] clr_now;
    logic               sw_wr;

    always_comb begin
        clr_now = (cfg_we && cfg_sel == SEL_W'(IDX_STAT)) ? cfg_wdata[NUM_DEV-1:0] : '0;
        sw_wr   = cfg_we && (cfg_sel == SEL_W'(IDX_SWSMI));
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!smi_req && dev_hit == '0));

    // R6
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(dev_hit & ~clr_now) & ~dev_hit) == '0));

    // R9
    a_r9_idle_bus_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_vld)) |-> ((dev_hit & ~$past(dev_hit)) == '0));

    // R7
    a_r7_new_flag_fires: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ((dev_hit & ~$past(dev_hit)) != '0)) |-> smi_req);

    // R7
    a_r7_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> $past(bus_vld || sw_wr));

    // R8
    a_r8_sw_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sw_wr)) |-> smi_req);
endmodule

bind trap_decoder trap_decoder_chk #(.NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dev_hit(dev_hit), .smi_req(smi_req)
);

// File: tb/tb_trap_decoder.sv
module tb_trap_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_vld = 1'b0, bus_mem = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [ND-1:0] dev_hit;
    logic        smi_req;

    trap_decoder dut (
        .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_mem(bus_mem),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_hit(dev_hit), .smi_req(smi_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [ND-1:0] st;
        logic          smi;
        string         tag;
    } exp_t;

    exp_t        sb_q[$];
    exp_t        mon_e;
    int          checks = 0;
    int          errors = 0;
    logic [15:0] m_base [ND];
    logic [7:0]  m_ctl  [ND];
    logic [ND-1:0] m_stat;

    // model of one window, from R2..R5
    function automatic logic win_hit(int i, logic m, logic w, logic [15:0] a);
        logic [15:0] d;
        d = a ^ m_base[i];
        if (m_ctl[i][7])
            return m && ((d[15:9] & ~m_ctl[i][6:0]) == 7'd0);
        return !m && (w ? m_ctl[i][6] : m_ctl[i][5]) &&
               (d[15:5] == 11'd0) && ((d[4:0] & ~m_ctl[i][4:0]) == 5'd0);
    endfunction

    function automatic logic [15:0] m_read(logic [3:0] s);
        if (s < 4'd3) return m_base[s];
        if (s >= 4'd4 && s < 4'd7) return {8'h00, m_ctl[s-4]};
        if (s == 4'd8) return {13'd0, m_stat};
        return 16'h0000;
    endfunction

    task automatic step(input logic v, input logic m, input logic w, input logic [15:0] a,
                        input logic we, input logic [3:0] sel, input logic [15:0] wd,
                        input string tag);
        logic [ND-1:0] hits;
        logic [ND-1:0] clr;
        logic          sw;
        exp_t          e;
        @(negedge clk);
        bus_vld = v; bus_mem = m; bus_wr = w; bus_addr = a;
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        for (int i = 0; i < ND; i++) hits[i] = v && win_hit(i, m, w, a);
        sw  = we && (sel == 4'd9);
        clr = (we && sel == 4'd8) ? wd[ND-1:0] : '0;
        m_stat = hits | (m_stat & ~clr);
        e.st = m_stat; e.smi = (|hits) || sw; e.tag = tag;
        sb_q.push_back(e);
        if (we && sel < 4'd3) m_base[sel] = wd;
        if (we && sel >= 4'd4 && sel < 4'd7) m_ctl[sel-4] = wd[7:0];
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd0, 16'h0000, tag);
    endtask

    task automatic wr(input logic [3:0] sel, input logic [15:0] wd, input string tag);
        step(1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, sel, wd, tag);
    endtask

    task automatic io(input logic w, input logic [15:0] a, input string tag);
        step(1'b1, 1'b0, w, a, 1'b0, 4'd0, 16'h0000, tag);
    endtask

    task automatic mem(input logic w, input logic [15:0] a, input string tag);
        step(1'b1, 1'b1, w, a, 1'b0, 4'd0, 16'h0000, tag);
    endtask

    task automatic rd_check(input logic [3:0] sel, input string tag);
        @(negedge clk);
        bus_vld = 1'b0; cfg_we = 1'b0; cfg_sel = sel;
        #1;
        checks++;
        if (cfg_rdata !== m_read(sel)) begin
            errors++;
            $display("FAIL %s: index %0d read %h expected %h", tag, sel, cfg_rdata, m_read(sel));
        end
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            mon_e = sb_q.pop_front();
            checks++;
            if (dev_hit !== mon_e.st || smi_req !== mon_e.smi) begin
                errors++;
                $display("FAIL %s: status=%b smi=%b expected status=%b smi=%b",
                         mon_e.tag, dev_hit, smi_req, mon_e.st, mon_e.smi);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < ND; i++) begin m_base[i] = '0; m_ctl[i] = '0; end
        m_stat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (dev_hit !== '0 || smi_req !== 1'b0) begin
            errors++;
            $display("FAIL R1: status=%b smi=%b expected status=000 smi=0", dev_hit, smi_req);
        end
        for (int s = 0; s < 10; s++) rd_check(4'(s), "R1");

        // R11 configuration and readback
        wr(4'd0, 16'h0120, "R11"); wr(4'd4, 16'h0063, "R11");
        wr(4'd1, 16'h0120, "R11"); wr(4'd5, 16'h0040, "R11");
        wr(4'd2, 16'hA000, "R11"); wr(4'd6, 16'hFF83, "R11");
        for (int s = 0; s < 7; s++) rd_check(4'(s), "R11");

        // R2 I/O masking
        io(1'b1, 16'h0123, "R2");
        io(1'b0, 16'h0121, "R2");
        io(1'b1, 16'h0124, "R2");
        io(1'b1, 16'h1120, "R2");
        rd_check(4'd8, "R11");
        wr(4'd8, 16'h0007, "R6");

        // R7 two windows in one cycle, single pulse
        io(1'b1, 16'h0120, "R7");
        idle("R7");
        wr(4'd8, 16'h0007, "R6");

        // R4 / R3 direction tracking
        io(1'b0, 16'h0120, "R4");
        wr(4'd4, 16'h0043, "R4");
        io(1'b0, 16'h0120, "R4");
        wr(4'd4, 16'h0023, "R3");
        io(1'b1, 16'h0122, "R3");
        io(1'b0, 16'h0122, "R4");
        wr(4'd8, 16'h0007, "R6");

        // R5 memory windows
        mem(1'b0, 16'hA3FF, "R5");
        wr(4'd8, 16'h0004, "R6");
        mem(1'b1, 16'hA5FF, "R5");
        wr(4'd8, 16'h0004, "R6");
        mem(1'b0, 16'hA800, "R5");
        io(1'b1, 16'hA000, "R5");
        mem(1'b1, 16'h0120, "R5");

        // R6 set beats clear, zero write no effect, sticky across idle
        mem(1'b0, 16'hA000, "R6");
        step(1'b1, 1'b1, 1'b0, 16'hA000, 1'b1, 4'd8, 16'h0004, "R6");
        idle("R6");
        wr(4'd8, 16'h0000, "R6");
        rd_check(4'd8, "R6");
        wr(4'd8, 16'h0004, "R6");

        // R8 software trigger
        wr(4'd9, 16'h0000, "R8");
        idle("R8");
        wr(4'd9, 16'hBEEF, "R8");
        rd_check(4'd9, "R8");

        // R9 strobe low ignored
        step(1'b0, 1'b1, 1'b0, 16'hA000, 1'b0, 4'd0, 16'h0000, "R9");
        step(1'b0, 1'b0, 1'b1, 16'h0120, 1'b0, 4'd0, 16'h0000, "R9");
        rd_check(4'd8, "R9");

        // R10 config write with concurrent bus cycle uses old settings
        step(1'b1, 1'b1, 1'b0, 16'hA000, 1'b1, 4'd6, 16'h0000, "R10");
        wr(4'd8, 16'h0007, "R10");
        mem(1'b0, 16'hA000, "R10");
        idle("R10");
        idle("R10");

        @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule